// File: doc/BRIEF.md
# Conversion Control Sequencer for a Successive-Approximation ADC

This block owns the control word of a successive-approximation converter and decides when a conversion starts, how long it runs and what happens when it ends. Software writes an 8-bit control word (enable, start, free-running, interrupt flag, prescaler code) and, at a second select, a channel-select value. From these writes the block derives the converter clock divide, runs a conversion timer in system clocks and, at the end, raises the interrupt flag, captures the conversion result and emits a one-cycle completion pulse.

A start emits a one-cycle trigger pulse that carries the channel selection sampled at that instant. The completion pulse carries the same captured selection, so a consumer can match a result to its channel even if the channel register has since changed. The analog part is not modelled: the result value arrives on an input port and is loaded at completion. In free-running mode every completion immediately launches the next conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control readback is 0x00, result_q is 0, and neither trig_valid nor done_valid is high; a reset during a conversion cancels it.
- R2: Control word layout (wr_sel=0): bit 7 enable, bit 6 start, bit 5 free-running, bit 4 interrupt flag, bits 2:0 prescaler code; bit 3 reads 0. Writes with wr_sel=1 load the channel select from wr_data[MUX_W-1:0] and leave the control word unchanged.
- R3: A control write with bits 7 and 6 both 1 while the start bit reads 0 sets the start bit and pulses trig_valid for one cycle, in the cycle after the write edge, with trig_mux equal to the channel select held before that edge.
- R4: Writing 0 to the start bit while it reads 1 and enable stays 1 leaves the start bit at 1 and the conversion running.
- R5: A start written together with enable 0 is ignored: the start bit stays 0 and no trigger pulse appears.
- R6: A conversion lasts D*K system clocks from its start edge to its completion edge, where D is 2 to the power of the prescaler code, and code 0 gives D = 2.
- R7: K is 25 for the first conversion after a 0-to-1 change of the enable bit and 13 for every later one.
- R8: At completion the interrupt flag becomes 1, the start bit clears (unless free-running), result_q is loaded with conv_data right-aligned, and done_valid pulses for one cycle with done_mux equal to the selection captured at that conversion's start.
- R9: A control write with bit 4 = 1 clears the interrupt flag, a write with bit 4 = 0 leaves it; a completion in the same cycle wins and sets it.
- R10: A control write that changes enable from 1 to 0 aborts any conversion: the start bit clears, no completion pulse follows and the flag is not set.
- R11: With bit 5 set, a completion starts the next conversion on the same edge: the start bit stays 1, trig_valid pulses with the selection held at that edge, and the new conversion uses K = 13 and the prescaler held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 the channel select |
| wr_data | input | 8 | Write data |
| conv_data | input | RES_W | Conversion result supplied from outside |
| ctrl_q | output | 8 | Control word readback |
| trig_valid | output | 1 | One-cycle pulse when a conversion starts |
| trig_mux | output | MUX_W | Channel selection sampled at the start |
| done_valid | output | 1 | One-cycle pulse when a conversion completes |
| done_mux | output | MUX_W | Channel selection of the completed conversion |
| result_q | output | OUT_W | Result register, loaded at completion |

## Verification
The checker relies on writes arriving only through wr_en, one register per cycle, and on the enable bit never being 0 while the start bit is 1, which the block guarantees by construction of its inputs being plain register writes. It assumes conversions are at least 26 clocks apart between a trigger and the matching completion, true for every prescaler code. The stimulus issues each write as a single-cycle strobe driven between clock edges, asserts reset only away from the active edge, and places stop, abort and channel-change writes in the middle of running conversions so every ordering the model covers is reached.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int CTRL_W = 8;

   // Control word bit positions: software decodes these.
   typedef struct packed {
      logic       en;
      logic       start;
      logic       free_run;
      logic       flag;
      logic       rsv;
      logic [2:0] ps;
   } ctrl_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int PS_W  = 3,
   parameter int MUX_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              complete,
   input  logic              restart,
   output logic              en_q,
   output logic              start_q,
   output logic              fr_q,
   output logic              flag_q,
   output logic [PS_W-1:0]   ps_q,
   output logic [MUX_W-1:0]  mux_q,
   output logic              en_nx,
   output logic              fr_nx,
   output logic              go,
   output logic              go_first,
   output logic [PS_W-1:0]   go_ps,
   output logic              abort
);

   ctrl_t wf;
   logic  wr_ctrl;
   logic  wr_mux;
   logic  rise;
   logic  first_q;

   assign wf       = ctrl_t'(wr_data);
   assign wr_ctrl  = wr_en & ~wr_sel;
   assign wr_mux   = wr_en & wr_sel;
   assign rise     = wr_ctrl & ~en_q & wf.en;
   assign abort    = wr_ctrl & en_q & ~wf.en;
   assign go       = wr_ctrl & wf.en & wf.start & ~start_q;
   assign go_first = first_q | rise;
   assign go_ps    = wf.ps[PS_W-1:0];
   assign en_nx    = wr_ctrl ? wf.en : en_q;
   assign fr_nx    = wr_ctrl ? wf.free_run : fr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         start_q <= 1'b0;
         fr_q    <= 1'b0;
         flag_q  <= 1'b0;
         ps_q    <= '0;
         mux_q   <= '0;
         first_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q <= wf.en;
            fr_q <= wf.free_run;
            ps_q <= wf.ps[PS_W-1:0];
         end
         if (wr_mux)
            mux_q <= wr_data[MUX_W-1:0];
         if (complete)
            flag_q <= 1'b1;
         else if (wr_ctrl && wf.flag)
            flag_q <= 1'b0;
         if (abort)
            start_q <= 1'b0;
         else if (go)
            start_q <= 1'b1;
         else if (complete && !restart)
            start_q <= 1'b0;
         if (rise)
            first_q <= 1'b1;
         else if (complete)
            first_q <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int PS_W      = 3,
   parameter int CNT_W     = 12,
   parameter int FIRST_CYC = 25,
   parameter int NORM_CYC  = 13
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            go_first,
   input  logic [PS_W-1:0] go_ps,
   input  logic            abort,
   input  logic            complete,
   input  logic            restart,
   input  logic [PS_W-1:0] ps_q,
   output logic            expire
);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   // Reload value: (cycles << shift) - 1, code 0 shifts like code 1.
   function automatic logic [CNT_W-1:0] span(input logic [PS_W-1:0] ps, input logic first);
      logic [CNT_W-1:0] base;
      int               sh;
      base = first ? CNT_W'(FIRST_CYC) : CNT_W'(NORM_CYC);
      sh   = (ps == '0) ? 1 : int'(ps);
      return (base << sh) - CNT_W'(1);
   endfunction

   assign expire = busy_q & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
      end else if (go) begin
         busy_q <= 1'b1;
         cnt_q  <= span(go_ps, go_first);
      end else if (complete) begin
         if (restart)
            cnt_q <= span(ps_q, 1'b0);
         else
            busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
   parameter int MUX_W    = 4,
   parameter int RES_W    = 10,
   parameter int OUT_W    = 16,
   parameter bit LEFT_ADJ = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             complete,
   input  logic [MUX_W-1:0] mux_q,
   input  logic [RES_W-1:0] conv_data,
   output logic             trig_valid,
   output logic [MUX_W-1:0] trig_mux,
   output logic             done_valid,
   output logic [MUX_W-1:0] done_mux,
   output logic [OUT_W-1:0] result_q
);

   localparam int PAD_W = OUT_W - RES_W;

   logic [MUX_W-1:0] lat_q;
   logic [OUT_W-1:0] aligned;

   generate
      if (PAD_W == 0) begin : g_exact
         assign aligned = conv_data;
      end else if (LEFT_ADJ) begin : g_left
         assign aligned = {conv_data, {PAD_W{1'b0}}};
      end else begin : g_right
         assign aligned = {{PAD_W{1'b0}}, conv_data};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q      <= '0;
         trig_valid <= 1'b0;
         trig_mux   <= '0;
         done_valid <= 1'b0;
         done_mux   <= '0;
         result_q   <= '0;
      end else begin
         trig_valid <= launch;
         done_valid <= complete;
         if (launch) begin
            lat_q    <= mux_q;
            trig_mux <= mux_q;
         end
         if (complete) begin
            done_mux <= lat_q;
            result_q <= aligned;
         end
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int PS_W      = 3,
   parameter int MUX_W     = 4,
   parameter int RES_W     = 10,
   parameter int OUT_W     = 16,
   parameter bit LEFT_ADJ  = 1'b0,
   parameter int FIRST_CYC = 25,
   parameter int NORM_CYC  = 13
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [7:0]        wr_data,
   input  logic [RES_W-1:0]  conv_data,
   output logic [7:0]        ctrl_q,
   output logic              trig_valid,
   output logic [MUX_W-1:0]  trig_mux,
   output logic              done_valid,
   output logic [MUX_W-1:0]  done_mux,
   output logic [OUT_W-1:0]  result_q
);

   localparam int MAX_SH  = (1 << PS_W) - 1;
   localparam int MAX_LEN = FIRST_CYC << MAX_SH;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (PS_W < 1 || PS_W > 3) begin : g_bad_ps
         $error("PS_W must fit the 3-bit prescaler field");
      end
      if (MUX_W < 1 || MUX_W > CTRL_W) begin : g_bad_mux
         $error("MUX_W must fit the write data");
      end
      if (OUT_W < RES_W) begin : g_bad_out
         $error("OUT_W must hold RES_W");
      end
      if (NORM_CYC < 1 || FIRST_CYC < NORM_CYC) begin : g_bad_cyc
         $error("first conversion must not be shorter than a normal one");
      end
   endgenerate

   logic            en_q, start_q, fr_q, flag_q;
   logic [PS_W-1:0] ps_q, go_ps;
   logic [MUX_W-1:0] mux_q;
   logic            en_nx, fr_nx, go, go_first, abort;
   logic            expire, complete, restart;

   assign complete = expire & en_nx & ~abort;
   assign restart  = complete & fr_nx;

   adc_seq_regs #(.PS_W(PS_W), .MUX_W(MUX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .complete(complete), .restart(restart),
      .en_q(en_q), .start_q(start_q), .fr_q(fr_q), .flag_q(flag_q), .ps_q(ps_q),
      .mux_q(mux_q), .en_nx(en_nx), .fr_nx(fr_nx), .go(go), .go_first(go_first),
      .go_ps(go_ps), .abort(abort)
   );

   adc_seq_timer #(.PS_W(PS_W), .CNT_W(CNT_W), .FIRST_CYC(FIRST_CYC), .NORM_CYC(NORM_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(go), .go_first(go_first), .go_ps(go_ps),
      .abort(abort), .complete(complete), .restart(restart), .ps_q(ps_q),
      .expire(expire)
   );

   adc_seq_result #(.MUX_W(MUX_W), .RES_W(RES_W), .OUT_W(OUT_W), .LEFT_ADJ(LEFT_ADJ)) u_result (
      .clk(clk), .rst_n(rst_n), .launch(go | restart), .complete(complete),
      .mux_q(mux_q), .conv_data(conv_data),
      .trig_valid(trig_valid), .trig_mux(trig_mux),
      .done_valid(done_valid), .done_mux(done_mux), .result_q(result_q)
   );

   assign ctrl_q = {en_q, start_q, fr_q, flag_q, 1'b0, 3'(ps_q)};

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int NORM_CYC = 13
)(
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] ctrl_q,
   input logic       trig_valid,
   input logic       done_valid
);

   logic [15:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= '0;
      else if (trig_valid)
         gap_q <= 16'd1;
      else if (gap_q != 16'hFFFF)
         gap_q <= gap_q + 16'd1;
   end

   assert_trig_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q[6]) |-> trig_valid);

   assert_start_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q[6]) |-> (done_valid || !ctrl_q[7]));

   assert_no_start_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[7] |-> !ctrl_q[6]);

   assert_min_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (gap_q >= 16'(2 * NORM_CYC)));

   assert_done_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> ctrl_q[4]);

   assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q[7]) |-> (!done_valid && !ctrl_q[6]));

   assert_free_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && ctrl_q[5]) |-> (trig_valid && ctrl_q[6]));

   assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !ctrl_q[5]) |-> !trig_valid);

endmodule

bind adc_seq_ctrl adc_seq_chk #(.NORM_CYC(NORM_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q),
   .trig_valid(trig_valid), .done_valid(done_valid)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

   localparam int MUX_W = 4;
   localparam int RES_W = 10;
   localparam int OUT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             wr_sel = 1'b0;
   logic [7:0]       wr_data = '0;
   logic [RES_W-1:0] conv_data = '0;
   logic [7:0]       ctrl_q;
   logic             trig_valid;
   logic [MUX_W-1:0] trig_mux;
   logic             done_valid;
   logic [MUX_W-1:0] done_mux;
   logic [OUT_W-1:0] result_q;

   int n_vec = 0;
   int n_bad = 0;
   int n_done = 0;
   int cyc = 0;
   bit started = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   adc_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .conv_data(conv_data), .ctrl_q(ctrl_q), .trig_valid(trig_valid),
      .trig_mux(trig_mux), .done_valid(done_valid), .done_mux(done_mux),
      .result_q(result_q)
   );

   // ---------------- behavioural reference ----------------
   bit m_en, m_start, m_auto, m_flag, m_first, m_busy, m_trig, m_done;
   int m_ps, m_mux, m_cnt, m_lat, m_tmux, m_dmux, m_res;

   function automatic int conv_len(int ps, bit first);
      int d;
      d = (ps == 0) ? 2 : (1 << ps);
      return d * (first ? 25 : 13);
   endfunction

   always @(posedge clk) begin
      int  o_mux, o_ps;
      bit  fire;
      logic [7:0] v;
      if (!rst_n) begin
         m_en = 0; m_start = 0; m_auto = 0; m_flag = 0; m_first = 0; m_busy = 0;
         m_trig = 0; m_done = 0; m_ps = 0; m_mux = 0; m_cnt = 0; m_lat = 0;
         m_tmux = 0; m_dmux = 0; m_res = 0;
         started = 1;
      end else begin
         m_trig = 0; m_done = 0;
         o_mux = m_mux; o_ps = m_ps;
         fire = m_busy && (m_cnt == 0);
         if (m_busy && m_cnt != 0) m_cnt--;
         if (wr_en && !wr_sel) begin
            v = wr_data;
            if (m_en && !v[7]) begin m_busy = 0; m_start = 0; fire = 0; end
            if (!m_en && v[7]) m_first = 1;
            m_en = v[7]; m_auto = v[5]; m_ps = int'(v[2:0]);
            if (v[4]) m_flag = 0;
            if (v[7] && v[6] && !m_start) begin
               m_start = 1; m_busy = 1; m_cnt = conv_len(m_ps, m_first) - 1;
               m_trig = 1; m_tmux = o_mux; m_lat = o_mux;
            end
         end else if (wr_en && wr_sel) begin
            m_mux = int'(wr_data[MUX_W-1:0]);
         end
         if (fire) begin
            m_flag = 1; m_res = int'(conv_data); m_done = 1; m_dmux = m_lat; m_first = 0;
            if (m_auto) begin
               m_cnt = conv_len(o_ps, 0) - 1; m_trig = 1; m_tmux = o_mux; m_lat = o_mux;
            end else begin
               m_start = 0; m_busy = 0;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (started && !ended) begin
         int exp_ctrl;
         exp_ctrl = (int'(m_en) << 7) | (int'(m_start) << 6) | (int'(m_auto) << 5) |
                    (int'(m_flag) << 4) | m_ps;
         chk(int'(ctrl_q) == exp_ctrl, "R2", "ctrl_q", int'(ctrl_q), exp_ctrl);
         chk(trig_valid == m_trig, "R3", "trig_valid", int'(trig_valid), int'(m_trig));
         if (m_trig) chk(int'(trig_mux) == m_tmux, "R3", "trig_mux", int'(trig_mux), m_tmux);
         chk(done_valid == m_done, "R8", "done_valid", int'(done_valid), int'(m_done));
         if (m_done) chk(int'(done_mux) == m_dmux, "R8", "done_mux", int'(done_mux), m_dmux);
         chk(int'(result_q) == m_res, "R8", "result_q", int'(result_q), m_res);
      end
      if (done_valid) n_done++;
   end

   task automatic finish_run();
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         finish_run();
      end
   end

   task automatic wr(input bit sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // counts negedges after the trigger cycle until done is seen
   task automatic wait_done(output int n);
      n = 0;
      while (n < 5000) begin
         @(negedge clk);
         n++;
         if (done_valid) return;
      end
      n = -1;
   endtask

   initial begin
      int len;
      int d0;
      idle(3);
      @(negedge clk); #1 rst_n = 1'b1;
      idle(2);
      // R1: reset state
      chk(ctrl_q == 8'h00 && !trig_valid && !done_valid && result_q == '0,
          "R1", "reset state", int'(ctrl_q), 0);

      // R5: start with enable low ignored
      wr(1'b0, 8'h40);
      chk(!trig_valid && ctrl_q[6] == 1'b0, "R5", "start while disabled", int'(ctrl_q), 0);

      // R2: channel write leaves control word
      wr(1'b1, 8'h05);
      chk(ctrl_q == 8'h00, "R2", "mux write isolation", int'(ctrl_q), 0);

      // first conversion, prescaler code 0
      conv_data = 10'h2A5;
      wr(1'b0, 8'hC0);
      chk(trig_valid && trig_mux == 4'd5, "R3", "trigger on start", int'(trig_mux), 5);
      wait_done(len);
      chk(len == 50, "R7", "first conversion length ps0", len, 50);
      chk(ctrl_q[4] && !ctrl_q[6] && result_q == 16'h02A5 && done_mux == 4'd5,
          "R8", "completion state", int'(result_q), 16'h02A5);

      // R9: flag clear semantics
      wr(1'b0, 8'h80);
      chk(ctrl_q[4] == 1'b1, "R9", "flag kept on write 0", int'(ctrl_q[4]), 1);
      wr(1'b0, 8'h90);
      chk(ctrl_q[4] == 1'b0, "R9", "flag cleared on write 1", int'(ctrl_q[4]), 0);

      // R4: writing 0 to start while running; ps1 later conversion
      wr(1'b1, 8'h03);
      conv_data = 10'h13C;
      wr(1'b0, 8'hC1);
      idle(5);
      wr(1'b0, 8'h81);
      chk(ctrl_q[6] == 1'b1, "R4", "start bit held", int'(ctrl_q[6]), 1);
      wait_done(len);
      chk(len > 0 && done_mux == 4'd3 && result_q == 16'h013C, "R8", "done after hold", int'(done_mux), 3);

      // R6: prescaler 2 and 7
      wr(1'b0, 8'hC2);
      wait_done(len);
      chk(len == 52, "R6", "length ps2", len, 52);
      wr(1'b0, 8'hC7);
      wait_done(len);
      chk(len == 1664, "R6", "length ps7", len, 1664);

      // R10: abort on disable
      wr(1'b0, 8'h90);
      wr(1'b0, 8'hC3);
      idle(10);
      d0 = n_done;
      wr(1'b0, 8'h03);
      chk(ctrl_q == 8'h03, "R10", "abort clears start", int'(ctrl_q), 3);
      idle(200);
      chk(n_done == d0 && !ctrl_q[4], "R10", "no completion after abort", n_done, d0);

      // R7: re-enable gives first conversion again
      wr(1'b0, 8'hC0);
      wait_done(len);
      chk(len == 50, "R7", "first after re-enable", len, 50);

      // R11: free-running
      wr(1'b1, 8'h02);
      wr(1'b0, 8'hB0);
      wr(1'b0, 8'hE0);
      wait_done(len);
      chk(len == 26, "R11", "free-run first length (not first)", len, 26);
      chk(trig_valid && ctrl_q[6] && trig_mux == 4'd2, "R11", "restart at completion", int'(trig_mux), 2);
      idle(4);
      wr(1'b1, 8'h06);
      wait_done(len);
      chk(done_mux == 4'd2 && trig_mux == 4'd6 && trig_valid, "R11", "restart samples new mux",
          int'(trig_mux), 6);
      idle(4);
      wr(1'b0, 8'hC0);
      wait_done(len);
      chk(ctrl_q[6] == 1'b0 && !trig_valid, "R11", "stop after free-run off", int'(ctrl_q), 8'h90);

      // R12-style reset mid conversion (R1)
      wr(1'b0, 8'hC7);
      idle(20);
      @(negedge clk); #1 rst_n = 1'b0;
      idle(2);
      @(negedge clk); #1 rst_n = 1'b1;
      d0 = n_done;
      idle(100);
      chk(ctrl_q == 8'h00 && n_done == d0 && result_q == '0, "R1", "reset cancels conversion",
          int'(ctrl_q), 0);

      idle(3);
      finish_run();
   end

endmodule